// File: doc/BRIEF.md
# Dual-Bank Video Memory Address Interleaver

This block sits between a video display processor's fetch logic and two byte-wide DRAM banks. It takes a 17-bit byte address with a read or write strobe and produces per-bank enables and a 16-bit offset for each bank. It also steers the returned bytes back onto a 16-bit read bus. Two mappings exist. In the ordinary display modes the banks are stacked end to end: the lower 64K sits in bank 0 and the upper 64K in bank 1, each at the same offset. In the wide-fetch graphics mode, even bytes live in bank 0 and odd bytes in bank 1. A read then drives one offset onto both banks at once and returns the whole even/odd pair in a single access.

Each request owns the bank interface for one address-phase cycle. Read data comes back at the edge that closes that phase. The mode select is sampled only when a request is accepted, so a mode switch never splits an access. The block does no translation between the two layouts. Software that switches into or out of the wide mode must reload video memory afterwards, because bytes stored under one mapping sit at other places under the other.

Top module: `vram_interleaver`

## Requirements
- R1: In linear mode (`mode_wide`=0) a request for an address below 0x10000 enables only bank 0 (`bank_en`=2'b01), and an address at 0x10000 or above enables only bank 1 (`bank_en`=2'b10). In both cases `bank0_addr` and `bank1_addr` carry the address bits [15:0].
- R2: A wide-mode read enables both banks (`bank_en`=2'b11), drives both bank addresses with the byte address shifted right by one, and raises `pair_fetch`.
- R3: A wide-mode read returns the bank 0 byte on `rd_data[7:0]` and the bank 1 byte on `rd_data[15:8]`. An odd address returns the same pair as the even address below it.
- R4: A linear read returns the byte of the selected bank on `rd_data[7:0]` with `rd_data[15:8]`=0, and `pair_fetch` stays low.
- R5: A write raises `bank_we` with exactly one bank enabled and `bank_wdata` equal to the request byte. In linear mode the bank is address bit 16 and the offset is bits [15:0]. In wide mode the bank is address bit 0 and the offset is the address shifted right by one. `pair_fetch` stays low for writes.
- R6: A request is accepted at a rising edge where `req_valid` and `req_ready` are both high. Bank outputs are active for exactly the following cycle. For a read, `rd_valid` is high for the one cycle after that, with `rd_data` captured from the bank inputs during the address phase. A write never raises `rd_valid`.
- R7: `mode_wide` is latched at acceptance. Changing it during the address phase does not alter the bank enables, addresses or data steering of the request in flight.
- R8: `req_ready` is low during the address phase. A request presented in that cycle is ignored and causes no bank activity afterwards.
- R9: No mapping translation is done. Bytes written in one mode read back rearranged in the other.
- R10: After reset `req_ready`=1, and `bank_en`, `bank_we`, `pair_fetch` and `rd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wide | input | 1 | 1 selects the even/odd interleaved mapping |
| req_valid | input | 1 | Access request strobe |
| req_we | input | 1 | 1 = byte write, 0 = read |
| req_addr | input | 17 | Linear byte address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | High when a request can be accepted |
| bank_en | output | 2 | Per-bank enable, bit n for bank n |
| bank_we | output | 1 | Write strobe to the enabled bank |
| bank0_addr | output | 16 | Bank 0 offset |
| bank1_addr | output | 16 | Bank 1 offset |
| bank_wdata | output | 8 | Write byte to the banks |
| pair_fetch | output | 1 | Two-byte paired read in progress |
| bank0_rdata | input | 8 | Bank 0 read byte |
| bank1_rdata | input | 8 | Bank 1 read byte |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Read data: even/low byte in [7:0] |

## Verification
A mode switch and an in-flight access can fall in the same cycle. The bench accepts a request and then flips `mode_wide` during that request's address phase, in both directions. It judges the bank enables, offsets and returned pair against the mode that was present at acceptance. A second overlap is a new request arriving while the previous one is still in its address phase. The bench holds `req_valid` high with a different address through that cycle and confirms that no bank becomes active afterwards.

// File: rtl/vilv_pkg.sv
package vilv_pkg;

  // Access class formed from {wide mode, write}; bit 0 is the write flag.
  typedef enum logic [1:0] {
    ACC_LIN_RD  = 2'd0,
    ACC_LIN_WR  = 2'd1,
    ACC_WIDE_RD = 2'd2,
    ACC_WIDE_WR = 2'd3
  } acc_kind_t;

  function automatic acc_kind_t classify(input logic wide, input logic we);
    return acc_kind_t'({wide, we});
  endfunction

  function automatic logic is_write(input acc_kind_t k);
    return (k == ACC_LIN_WR) || (k == ACC_WIDE_WR);
  endfunction

  function automatic logic is_wide(input acc_kind_t k);
    return (k == ACC_WIDE_RD) || (k == ACC_WIDE_WR);
  endfunction

endpackage

// File: rtl/vilv_req_stage.sv
module vilv_req_stage
  import vilv_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wide,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              busy,
  output logic              accept,
  output acc_kind_t         kind_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DW-1:0]     wdata_q
);

  // Accept only outside the address phase; the mode is captured here.
  assign accept = req_valid && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      kind_q  <= ACC_LIN_RD;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      busy <= accept;
      if (accept) begin
        kind_q  <= classify(mode_wide, req_we);
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
    end
  end

  // The address phase lasts exactly one cycle.
  assert_single_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  // Latched request fields do not move while the phase closes (mode change ignored).
  assert_latched_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(kind_q) && $stable(addr_q) && $stable(wdata_q)));

endmodule

// File: rtl/vilv_addr_map.sv
module vilv_addr_map
  import vilv_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int NBANK  = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               busy,
  input  acc_kind_t                          kind,
  input  logic [ADDR_W-1:0]                  addr,
  output logic [NBANK-1:0]                   bank_en,
  output logic [NBANK-1:0][ADDR_W-2:0]       bank_addr,
  output logic                               pair
);

  localparam int BANK_AW = ADDR_W - 1;

  // Offset within a bank under the stacked mapping.
  function automatic logic [BANK_AW-1:0] stacked_offset(input logic [ADDR_W-1:0] a);
    return a[BANK_AW-1:0];
  endfunction

  // Offset within a bank under the even/odd mapping.
  function automatic logic [BANK_AW-1:0] woven_offset(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:1];
  endfunction

  // Bank that a single-byte access lands in.
  function automatic logic target_bank(input acc_kind_t k, input logic [ADDR_W-1:0] a);
    return is_wide(k) ? a[0] : a[ADDR_W-1];
  endfunction

  logic             tgt;
  logic [BANK_AW-1:0] offs;

  assign tgt  = target_bank(kind, addr);
  assign offs = is_wide(kind) ? woven_offset(addr) : stacked_offset(addr);
  assign pair = busy && (kind == ACC_WIDE_RD);

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    assign bank_en[g]   = busy && ((kind == ACC_WIDE_RD) || (tgt == g[0]));
    assign bank_addr[g] = offs;
  end

  // A paired fetch drives both banks with one shared offset.
  assert_pair_both_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pair |-> (bank_en == 2'b11) && (bank_addr[0] == bank_addr[1]));

  // Single-byte accesses touch exactly one bank.
  assert_single_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pair) |-> ($countones(bank_en) == 1));

  // Nothing is enabled outside the address phase.
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (bank_en == '0) && !pair);

endmodule

// File: rtl/vilv_lane_steer.sv
module vilv_lane_steer
  import vilv_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            busy,
  input  acc_kind_t       kind,
  input  logic            sel_hi,
  input  logic [DW-1:0]   rdata0,
  input  logic [DW-1:0]   rdata1,
  output logic            rd_valid,
  output logic [2*DW-1:0] rd_data
);

  // Even byte on the low lane, odd byte on the high lane.
  function automatic logic [2*DW-1:0] steer(input acc_kind_t k, input logic hi,
                                            input logic [DW-1:0] b0,
                                            input logic [DW-1:0] b1);
    if (k == ACC_WIDE_RD) return {b1, b0};
    return {{DW{1'b0}}, (hi ? b1 : b0)};
  endfunction

  logic capture;
  assign capture = busy && !is_write(kind);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= capture;
      if (capture) rd_data <= steer(kind, sel_hi, rdata0, rdata1);
    end
  end

  // Read data arrives only right after a read address phase.
  assert_rd_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(busy) && !$past(is_write(kind)));

  // Single-byte reads leave the high lane clear.
  assert_linear_hi_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && ($past(kind) != ACC_WIDE_RD)) |-> (rd_data[2*DW-1:DW] == '0));

endmodule

// File: rtl/vram_interleaver.sv
module vram_interleaver
  import vilv_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wide,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              req_ready,
  output logic [1:0]        bank_en,
  output logic              bank_we,
  output logic [ADDR_W-2:0] bank0_addr,
  output logic [ADDR_W-2:0] bank1_addr,
  output logic [DW-1:0]     bank_wdata,
  output logic              pair_fetch,
  input  logic [DW-1:0]     bank0_rdata,
  input  logic [DW-1:0]     bank1_rdata,
  output logic              rd_valid,
  output logic [2*DW-1:0]   rd_data
);

  localparam int BANK_AW = ADDR_W - 1;

  // Named internal events for the assertions.
  logic                     busy;
  logic                     accept;
  acc_kind_t                kind_q;
  logic [ADDR_W-1:0]        addr_q;
  logic [DW-1:0]            wdata_q;
  logic [1:0][BANK_AW-1:0]  bank_addr;

  vilv_req_stage #(.ADDR_W(ADDR_W), .DW(DW)) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_wide (mode_wide),
    .req_valid (req_valid),
    .req_we    (req_we),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .busy      (busy),
    .accept    (accept),
    .kind_q    (kind_q),
    .addr_q    (addr_q),
    .wdata_q   (wdata_q)
  );

  vilv_addr_map #(.ADDR_W(ADDR_W), .NBANK(2)) u_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .kind      (kind_q),
    .addr      (addr_q),
    .bank_en   (bank_en),
    .bank_addr (bank_addr),
    .pair      (pair_fetch)
  );

  vilv_lane_steer #(.DW(DW)) u_steer (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .kind     (kind_q),
    .sel_hi   (addr_q[ADDR_W-1]),
    .rdata0   (bank0_rdata),
    .rdata1   (bank1_rdata),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  assign req_ready  = !busy;
  assign bank_we    = busy && is_write(kind_q);
  assign bank_wdata = wdata_q;
  assign bank0_addr = bank_addr[0];
  assign bank1_addr = bank_addr[1];

  // An accepted request shows bank activity in the very next cycle.
  assert_accept_to_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (bank_en != 2'b00));

  // Writes never request a pair.
  assert_write_no_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |-> !pair_fetch);

  // Not ready while a request owns the banks.
  assert_ready_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_en != 2'b00) |-> !req_ready);

endmodule

// File: tb/sim_vram_interleaver.sv
module sim_vram_interleaver;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_wide, req_valid, req_we;
  logic [16:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_ready, bank_we, pair_fetch, rd_valid;
  logic [1:0]  bank_en;
  logic [15:0] bank0_addr, bank1_addr, rd_data;
  logic [7:0]  bank_wdata, bank0_rdata, bank1_rdata;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  vram_interleaver u0 (
    .clk(clk), .rst_n(rst_n), .mode_wide(mode_wide), .req_valid(req_valid),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .bank_en(bank_en), .bank_we(bank_we),
    .bank0_addr(bank0_addr), .bank1_addr(bank1_addr), .bank_wdata(bank_wdata),
    .pair_fetch(pair_fetch), .bank0_rdata(bank0_rdata), .bank1_rdata(bank1_rdata),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // Small bank model indexed by the low offset byte (test offsets never alias).
  logic [7:0] mem0 [256];
  logic [7:0] mem1 [256];
  assign bank0_rdata = mem0[bank0_addr[7:0]];
  assign bank1_rdata = mem1[bank1_addr[7:0]];
  always_ff @(posedge clk) begin
    if (bank_we && bank_en[0]) mem0[bank0_addr[7:0]] <= bank_wdata;
    if (bank_we && bank_en[1]) mem1[bank1_addr[7:0]] <= bank_wdata;
  end

  // Captured port values of the last access.
  logic [1:0]  c_en, c_en_after;
  logic [15:0] c_a0, c_a1, c_rd;
  logic [7:0]  c_wd;
  logic        c_we, c_pair, c_ready_ph, c_rv, c_rv_ph, c_ready_after;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic mode, input logic we, input logic [16:0] addr,
                       input logic [7:0] wd, input logic flip, input logic poke);
    @(negedge clk);
    mode_wide = mode; req_valid = 1'b1; req_we = we; req_addr = addr; req_wdata = wd;
    @(negedge clk);                       // address phase
    if (flip) mode_wide = ~mode;
    if (poke) req_addr = addr ^ 17'h10001; else req_valid = 1'b0;
    c_en = bank_en; c_a0 = bank0_addr; c_a1 = bank1_addr; c_we = bank_we;
    c_wd = bank_wdata; c_pair = pair_fetch; c_ready_ph = req_ready; c_rv_ph = rd_valid;
    @(negedge clk);                       // data returned
    req_valid = 1'b0; mode_wide = mode;
    c_rv = rd_valid; c_rd = rd_data; c_en_after = bank_en; c_ready_after = req_ready;
  endtask

  task automatic t_reset;
    chk("R10 ready", {31'd0, req_ready}, 1);
    chk("R10 en", {30'd0, bank_en}, 0);
    chk("R10 we/pair/rv", {29'd0, bank_we, pair_fetch, rd_valid}, 0);
  endtask

  task automatic t_linear;
    issue(0, 1, 17'h00005, 8'hA5, 0, 0);
    chk("R1 low bank en", {30'd0, c_en}, 2'b01);
    chk("R1 low offset", {16'd0, c_a0}, 16'h0005);
    chk("R5 lin write we/data", {23'd0, c_we, c_wd}, {1'b1, 8'hA5});
    chk("R6 write no rd_valid", {31'd0, c_rv}, 0);
    issue(0, 1, 17'h10005, 8'h5A, 0, 0);
    chk("R1 high bank en", {30'd0, c_en}, 2'b10);
    chk("R1 high offset", {16'd0, c_a1}, 16'h0005);
    issue(0, 0, 17'h00005, 8'h00, 0, 0);
    chk("R4 lin read low", {15'd0, c_rv, c_rd}, {1'b1, 16'h00A5});
    chk("R4 no pair", {31'd0, c_pair}, 0);
    issue(0, 0, 17'h10005, 8'h00, 0, 0);
    chk("R4 lin read high", {16'd0, c_rd}, 16'h005A);
    issue(0, 0, 17'h0FFFF, 8'h00, 0, 0);
    chk("R1 edge 0FFFF", {14'd0, c_en, c_a0}, {2'b01, 16'hFFFF});
    issue(0, 0, 17'h10000, 8'h00, 0, 0);
    chk("R1 edge 10000", {14'd0, c_en, c_a1}, {2'b10, 16'h0000});
  endtask

  task automatic t_wide;
    issue(1, 1, 17'h00008, 8'h11, 0, 0);
    chk("R5 wide even write", {14'd0, c_en, c_a0}, {2'b01, 16'h0004});
    issue(1, 1, 17'h00009, 8'h22, 0, 0);
    chk("R5 wide odd write", {14'd0, c_en, c_a1}, {2'b10, 16'h0004});
    chk("R5 write pair low", {31'd0, c_pair}, 0);
    issue(1, 0, 17'h00008, 8'h00, 0, 0);
    chk("R2 wide read en/pair", {29'd0, c_en, c_pair}, {2'b11, 1'b1});
    chk("R2 shared offset", {c_a1, c_a0}, {16'h0004, 16'h0004});
    chk("R3 lanes even", {15'd0, c_rv, c_rd}, {1'b1, 16'h2211});
    issue(1, 0, 17'h00009, 8'h00, 0, 0);
    chk("R3 lanes odd addr", {16'd0, c_rd}, 16'h2211);
    issue(1, 0, 17'h1FFFF, 8'h00, 0, 0);
    chk("R2 top offset", {c_a1, c_a0}, {16'hFFFF, 16'hFFFF});
  endtask

  task automatic t_layout;
    issue(0, 1, 17'h00020, 8'hC1, 0, 0);
    issue(0, 1, 17'h00021, 8'hC2, 0, 0);
    issue(1, 0, 17'h00020, 8'h00, 0, 0);
    chk("R9 lin-written read wide", {16'd0, c_rd}, 16'h0000);
    issue(1, 1, 17'h00040, 8'hD0, 0, 0);
    issue(1, 1, 17'h00041, 8'hD1, 0, 0);
    issue(0, 0, 17'h00041, 8'h00, 0, 0);
    chk("R9 wide-written odd not linear", {16'd0, c_rd}, 16'h0000);
    issue(0, 0, 17'h10020, 8'h00, 0, 0);
    chk("R9 odd byte seen high half", {16'd0, c_rd}, 16'h00D1);
    issue(0, 0, 17'h00020, 8'h00, 0, 0);
    chk("R9 even byte overwrote", {16'd0, c_rd}, 16'h00D0);
  endtask

  task automatic t_mode_flip;
    issue(1, 0, 17'h00008, 8'h00, 1, 0);
    chk("R7 wide kept en/pair", {29'd0, c_en, c_pair}, {2'b11, 1'b1});
    chk("R7 wide kept data", {16'd0, c_rd}, 16'h2211);
    issue(0, 0, 17'h10005, 8'h00, 1, 0);
    chk("R7 linear kept en/offset", {14'd0, c_en, c_a1}, {2'b10, 16'h0005});
    chk("R7 linear kept data", {16'd0, c_rd}, 16'h005A);
  endtask

  task automatic t_busy;
    issue(0, 0, 17'h00005, 8'h00, 0, 1);
    chk("R8 not ready in phase", {31'd0, c_ready_ph}, 0);
    chk("R8 ignored no activity", {30'd0, c_en_after}, 0);
    chk("R6 ready again", {31'd0, c_ready_after}, 1);
    chk("R6 rv timing", {30'd0, c_rv_ph, c_rv}, 2'b01);
    chk("R8 first request data", {16'd0, c_rd}, 16'h00A5);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin mem0[i] = 8'h00; mem1[i] = 8'h00; end
    rst_n = 1'b0; mode_wide = 1'b0; req_valid = 1'b0; req_we = 1'b0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_linear();
    t_wide();
    t_layout();
    t_mode_flip();
    t_busy();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule